// File: doc/BRIEF.md
# I/O Program Channel Sequencer

This block runs device I/O programs one at a time on behalf of a set of devices. A device raises its request line. Once the channel is free it is granted the channel, which stays locked to it until its program ends. The sequencer reads the program start address from that device's slot in a table in memory. It then fetches program doublewords through its own program counter. Each read or write order is passed to the device as a command, and the sequencer waits for the device to report that the block transfer is done.

While a command is running, the next program doubleword is prefetched into a holding buffer. When the device reports done and the buffer is already filled, the next order goes active in the following cycle. A jump order reloads the counter. An end order writes the counter back to the device's table slot, releases the grant and returns the channel to arbitration.

All memory traffic uses one valid/ready request port with a separate read response, and at most one read is outstanding at a time. The data path of the block transfers is not part of this block.

Top module: `chseq_top`

## Requirements
- R1: During reset and in the first cycle after it, the grant lines are all low, no memory request is valid and no command is issued.
- R2: When the channel is idle, the requesting device with the lowest index is granted one cycle after its request is seen, and at most one grant line is high at any time.
- R3: While a program runs, the grant stays on the same device and requests from other devices, including higher-priority ones, do not change it.
- R4: The first memory request after a grant is a read of the table slot at TBL_BASE plus the device index, and the low AW bits of the response become the program counter.
- R5: Program doublewords are read from consecutive addresses, starting at the table value, and the counter advances by one on every accepted program fetch.
- R6: The top two bits of a doubleword select the order: 00 read, 01 write, 10 jump, 11 end. A read or write order gives a one-cycle command with cmd_write low for read and high for write. Its cmd_count carries the low DW-2 bits.
- R7: A jump order issues no command. In the cycle after it is decoded, the next fetch is a read at its low AW bits.
- R8: While a command runs, the next doubleword is fetched. If that fetch has returned before the device reports done, the next command is issued in the cycle right after the done cycle.
- R9: An end order issues no command. It writes the counter value, which is the end word's address plus one, to the device's table slot. The grant drops in the cycle after that write is accepted.
- R10: A memory request stays valid with the same address and direction until it is accepted, and no request is raised while a read response is still owed.
- R11: After a program ends, the lowest-index device then requesting is granted next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dev_req | input | NDEV | Start requests, one per device |
| dev_grant | output | NDEV | One-hot channel grant, held for the whole program |
| cmd_valid | output | 1 | One-cycle pulse: a transfer order is issued to the granted device |
| cmd_write | output | 1 | Order direction, 1 for write, 0 for read |
| cmd_count | output | DW-2 | Operand of the issued order |
| dev_done | input | 1 | Pulse from the granted device: block transfer finished |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_write | output | 1 | 1 for the table write-back, 0 for reads |
| mem_req_addr | output | AW | Doubleword address |
| mem_req_wdata | output | DW | Write-back data, the program counter zero-extended |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | DW | Read response data |

## Verification
The grant is due one cycle after a request reaches an idle channel, and the table read is raised in the same cycle as the grant. A command is due one cycle after the fetch response that carries it, or one cycle after done when the prefetch has already landed. A jump's fetch is due one cycle after decode, and the grant drops one cycle after the write-back is accepted. The bench drives inputs and samples outputs on the falling edge. Its memory model decides acceptance from the same valid and ready values that the design samples at the next rising edge. Grant, priority and prefetch timing are therefore checked at the exact falling edge computed from these latencies. The order of fetch addresses, commands and write-backs is checked against scoreboard queues whenever each event appears.

// File: rtl/chseq_pkg.sv
package chseq_pkg;

  // order field of a program doubleword (top two bits)
  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_JUMP  = 2'b10,
    OP_END   = 2'b11
  } chseq_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_TBL,
    S_TBLW,
    S_FET,
    S_FETW,
    S_DEC,
    S_XFER,
    S_WB
  } chseq_state_e;

  typedef enum logic [1:0] {
    PF_IDLE,
    PF_REQ,
    PF_WAIT
  } chseq_pf_e;

endpackage

// File: rtl/chseq_arbiter.sv
module chseq_arbiter #(
  parameter int NDEV = 8,
  parameter int IW   = 3
) (
  input  logic [NDEV-1:0] req,
  output logic            any,
  output logic [NDEV-1:0] onehot,
  output logic [IW-1:0]   idx
);

  // fixed priority: the lowest index wins, so scan from the top down
  always_comb begin
    any    = 1'b0;
    onehot = '0;
    idx    = '0;
    for (int i = NDEV - 1; i >= 0; i--) begin
      if (req[i]) begin
        any       = 1'b1;
        onehot    = '0;
        onehot[i] = 1'b1;
        idx       = IW'(i);
      end
    end
  end

endmodule

// File: rtl/chseq_pcunit.sv
module chseq_pcunit #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc,
  output logic [AW-1:0] pc
);

  logic [AW-1:0] pc_q;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] v);
    return v + AW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pc_q <= '0;
    else if (load) pc_q <= load_val;
    else if (inc)  pc_q <= step(pc_q);
  end

  assign pc = pc_q;

endmodule

// File: rtl/chseq_pfbuf.sv
module chseq_pfbuf #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fill,
  input  logic [DW-1:0] fill_data,
  input  logic          take,
  output logic          full,
  output logic [DW-1:0] data
);

  logic          full_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (fill) begin
      full_q <= 1'b1;
      data_q <= fill_data;
    end else if (take) begin
      full_q <= 1'b0;
    end
  end

  assign full = full_q;
  assign data = data_q;

endmodule

// File: rtl/chseq_top.sv
module chseq_top
  import chseq_pkg::*;
#(
  parameter int          NDEV     = 8,
  parameter int          AW       = 16,
  parameter int          DW       = 32,
  parameter int unsigned TBL_BASE = 32'h0000_00F0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NDEV-1:0] dev_req,
  output logic [NDEV-1:0] dev_grant,
  output logic            cmd_valid,
  output logic            cmd_write,
  output logic [DW-3:0]   cmd_count,
  input  logic            dev_done,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic            mem_req_write,
  output logic [AW-1:0]   mem_req_addr,
  output logic [DW-1:0]   mem_req_wdata,
  input  logic            mem_rsp_valid,
  input  logic [DW-1:0]   mem_rsp_data
);

  localparam int IW = (NDEV > 1) ? $clog2(NDEV) : 1;
  localparam int CW = DW - 2;

  // ---------------- helpers ----------------
  function automatic logic [AW-1:0] tbl_addr(input logic [IW-1:0] i);
    return AW'(TBL_BASE) + AW'(i);
  endfunction

  function automatic chseq_op_e word_op(input logic [DW-1:0] w);
    return chseq_op_e'(w[DW-1 -: 2]);
  endfunction

  function automatic logic [AW-1:0] word_tgt(input logic [DW-1:0] w);
    return w[AW-1:0];
  endfunction

  function automatic logic [CW-1:0] word_cnt(input logic [DW-1:0] w);
    return w[CW-1:0];
  endfunction

  // ---------------- state ----------------
  chseq_state_e    state_q;
  chseq_pf_e       pf_st_q;
  logic [NDEV-1:0] grant_q;
  logic [IW-1:0]   gidx_q;
  logic [DW-1:0]   act_q;
  logic            done_seen_q;

  // ---------------- sub-blocks ----------------
  logic            arb_any;
  logic [NDEV-1:0] arb_oh;
  logic [IW-1:0]   arb_idx;

  chseq_arbiter #(.NDEV(NDEV), .IW(IW)) u_arb (
    .req    (dev_req),
    .any    (arb_any),
    .onehot (arb_oh),
    .idx    (arb_idx)
  );

  logic          pc_load;
  logic [AW-1:0] pc_load_val;
  logic          pc_inc;
  logic [AW-1:0] pc;

  chseq_pcunit #(.AW(AW)) u_pc (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (pc_load),
    .load_val (pc_load_val),
    .inc      (pc_inc),
    .pc       (pc)
  );

  logic          buf_fill;
  logic          buf_take;
  logic          buf_full;
  logic [DW-1:0] buf_data;

  chseq_pfbuf #(.DW(DW)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .fill      (buf_fill),
    .fill_data (mem_rsp_data),
    .take      (buf_take),
    .full      (buf_full),
    .data      (buf_data)
  );

  // ---------------- named events ----------------
  chseq_op_e     act_op;
  logic          mem_acc;
  logic          tbl_rsp_go;
  logic          prog_fetch_go;
  logic          pf_fetch_go;
  logic          cmd_fire;
  logic          jump_go;
  logic          end_go;
  logic          wb_go;
  logic          xfer_exit;
  logic [AW-1:0] jump_tgt;

  assign act_op        = word_op(act_q);
  assign jump_tgt      = word_tgt(act_q);
  assign mem_acc       = mem_req_valid & mem_req_ready;
  assign tbl_rsp_go    = (state_q == S_TBLW) & mem_rsp_valid;
  assign prog_fetch_go = (state_q == S_FET) & mem_acc;
  assign pf_fetch_go   = (state_q == S_XFER) & (pf_st_q == PF_REQ) & mem_acc;
  assign cmd_fire      = (state_q == S_DEC) & ((act_op == OP_READ) | (act_op == OP_WRITE));
  assign jump_go       = (state_q == S_DEC) & (act_op == OP_JUMP);
  assign end_go        = (state_q == S_DEC) & (act_op == OP_END);
  assign wb_go         = (state_q == S_WB) & mem_acc;
  assign buf_fill      = (state_q == S_XFER) & (pf_st_q == PF_WAIT) & mem_rsp_valid;
  assign xfer_exit     = (state_q == S_XFER) & (done_seen_q | dev_done) & buf_full;
  assign buf_take      = xfer_exit;

  // program counter control
  assign pc_load     = tbl_rsp_go | jump_go;
  assign pc_load_val = tbl_rsp_go ? mem_rsp_data[AW-1:0] : jump_tgt;
  assign pc_inc      = prog_fetch_go | pf_fetch_go;

  // ---------------- memory request ----------------
  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_write = 1'b0;
    mem_req_addr  = pc;
    mem_req_wdata = '0;
    case (state_q)
      S_TBL: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = tbl_addr(gidx_q);
      end
      S_FET: begin
        mem_req_valid = 1'b1;
      end
      S_XFER: begin
        mem_req_valid = (pf_st_q == PF_REQ);
      end
      S_WB: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b1;
        mem_req_addr  = tbl_addr(gidx_q);
        mem_req_wdata = DW'(pc);
      end
      default: ;
    endcase
  end

  // ---------------- device side ----------------
  assign cmd_valid = cmd_fire;
  assign cmd_write = (act_op == OP_WRITE);
  assign cmd_count = word_cnt(act_q);
  assign dev_grant = grant_q;

  // ---------------- sequencer ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      pf_st_q     <= PF_IDLE;
      grant_q     <= '0;
      gidx_q      <= '0;
      act_q       <= '0;
      done_seen_q <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (arb_any) begin
            grant_q <= arb_oh;
            gidx_q  <= arb_idx;
            state_q <= S_TBL;
          end
        end
        S_TBL:  if (mem_acc) state_q <= S_TBLW;
        S_TBLW: if (mem_rsp_valid) state_q <= S_FET;
        S_FET:  if (mem_acc) state_q <= S_FETW;
        S_FETW: begin
          if (mem_rsp_valid) begin
            act_q   <= mem_rsp_data;
            state_q <= S_DEC;
          end
        end
        S_DEC: begin
          if (cmd_fire) begin
            pf_st_q     <= PF_REQ;
            done_seen_q <= 1'b0;
            state_q     <= S_XFER;
          end else if (jump_go) begin
            state_q <= S_FET;
          end else if (end_go) begin
            state_q <= S_WB;
          end
        end
        S_XFER: begin
          if (pf_fetch_go) pf_st_q <= PF_WAIT;
          if (buf_fill)    pf_st_q <= PF_IDLE;
          if (dev_done)    done_seen_q <= 1'b1;
          if (xfer_exit) begin
            act_q   <= buf_data;
            state_q <= S_DEC;
          end
        end
        S_WB: begin
          if (wb_go) begin
            grant_q <= '0;
            state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/chseq_chk.sv
module chseq_chk #(
  parameter int NDEV = 8,
  parameter int AW   = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NDEV-1:0] dev_grant,
  input logic            cmd_valid,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic            mem_req_write,
  input logic [AW-1:0]   mem_req_addr,
  input logic            mem_rsp_valid,
  input logic            jump_go,
  input logic [AW-1:0]   jump_tgt
);

  // a read has been accepted and its response has not yet come back
  logic rd_open;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                               rd_open <= 1'b0;
    else if (mem_req_valid && mem_req_ready && !mem_req_write) rd_open <= 1'b1;
    else if (mem_rsp_valid)                                   rd_open <= 1'b0;
  end

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_grant));

  // R3
  grant_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|dev_grant) |=> (dev_grant == $past(dev_grant)) || (dev_grant == '0));

  // R4
  tbl_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|dev_grant) |-> mem_req_valid && !mem_req_write);

  // R6
  cmd_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (|dev_grant));

  // R7
  jump_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jump_go |=> mem_req_valid && !mem_req_write && (mem_req_addr == $past(jump_tgt)));

  // R9
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready && mem_req_write) |=> (dev_grant == '0));

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write));

  // R10
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_open |-> !mem_req_valid);

endmodule

bind chseq_top chseq_chk #(.NDEV(NDEV), .AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .dev_grant     (dev_grant),
  .cmd_valid     (cmd_valid),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_write (mem_req_write),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .jump_go       (jump_go),
  .jump_tgt      (jump_tgt)
);

// File: tb/chseq_top_test.sv
module chseq_top_test;

  localparam int NDEV = 8;
  localparam int AW   = 16;
  localparam int DW   = 32;
  localparam int CW   = DW - 2;
  localparam int CIW  = CW + 4;
  localparam logic [AW-1:0] TBASE = 16'h00F0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [NDEV-1:0] dev_req = '0;
  logic [NDEV-1:0] dev_grant;
  logic            cmd_valid, cmd_write;
  logic [CW-1:0]   cmd_count;
  logic            dev_done = 1'b0;
  logic            mem_req_valid, mem_req_write;
  logic            mem_req_ready = 1'b0;
  logic [AW-1:0]   mem_req_addr;
  logic [DW-1:0]   mem_req_wdata;
  logic            mem_rsp_valid = 1'b0;
  logic [DW-1:0]   mem_rsp_data = '0;

  chseq_top #(.NDEV(NDEV), .AW(AW), .DW(DW), .TBL_BASE(32'h0000_00F0)) uut (
    .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .dev_grant(dev_grant),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_count(cmd_count),
    .dev_done(dev_done), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int oh2i(input logic [NDEV-1:0] v);
    for (int i = 0; i < NDEV; i++) if (v[i]) return i;
    return 0;
  endfunction

  // ---------------- scoreboard queues ----------------
  logic [CIW-1:0]   exp_cmd[$];
  logic [AW-1:0]    exp_fetch[$];
  logic [AW+DW-1:0] exp_wb[$];

  logic [DW-1:0] mem [0:255];

  task automatic put(input int a, input logic [1:0] op, input int val);
    mem[a] = {op, CW'(val)};
    exp_fetch.push_back(AW'(a));
  endtask

  task automatic want_cmd(input int dev, input bit wr, input int cnt);
    exp_cmd.push_back({3'(dev), wr, CW'(cnt)});
  endtask

  task automatic want_wb(input int dev, input int pcv);
    exp_wb.push_back({TBASE + AW'(dev), DW'(pcv)});
  endtask

  // ---------------- request raising (token handed to monitor) ----------------
  logic [NDEV-1:0] raise_mask = '0;
  int raise_tok = 0;
  int tok_seen  = 0;

  task automatic raise(input logic [NDEV-1:0] m);
    @(posedge clk);
    raise_mask = m;
    raise_tok++;
  endtask

  // ---------------- memory ready pattern ----------------
  int unsigned cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_req_ready <= (cyc % 3) != 1;
  end

  // ---------------- memory / device model and monitor ----------------
  int              rdly = 0;
  logic [DW-1:0]   rdat = '0;
  logic            tbl_due = 1'b0;
  logic [NDEV-1:0] grant_seen = '0;
  int              ddly = 0;
  logic            hold_v = 1'b0;
  logic [AW-1:0]   hold_a = '0;
  logic            fast_mode = 1'b0;

  always @(negedge clk) begin
    mem_rsp_valid <= 1'b0;
    dev_done      <= 1'b0;
    if (rst_n) begin
      // R10: a refused request must still be there, unchanged
      if (hold_v) chk(mem_req_valid && (mem_req_addr == hold_a), "R10", 64'(mem_req_addr), 64'(hold_a));
      hold_v = mem_req_valid && !mem_req_ready;
      hold_a = mem_req_addr;

      if (dev_grant != grant_seen && dev_grant != '0) tbl_due = 1'b1;
      grant_seen = dev_grant;

      if (raise_tok != tok_seen) begin
        dev_req  = dev_req | raise_mask;
        tok_seen = raise_tok;
      end
      dev_req = dev_req & ~dev_grant;

      // read response delivery
      if (rdly > 0) begin
        rdly--;
        if (rdly == 0) begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data  <= rdat;
        end
      end

      // accepted request at the coming rising edge
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_write) begin
          mem[mem_req_addr[7:0]] = mem_req_wdata;
          if (exp_wb.size() == 0) chk(1'b0, "R9", 64'({mem_req_addr, mem_req_wdata}), 64'(0));
          else begin
            logic [AW+DW-1:0] e;
            e = exp_wb.pop_front();
            chk({mem_req_addr, mem_req_wdata} == e, "R9", 64'({mem_req_addr, mem_req_wdata}), 64'(e));
          end
        end else begin
          rdat = mem[mem_req_addr[7:0]];
          rdly = 2;
          if (tbl_due) begin
            chk(mem_req_addr == TBASE + AW'(oh2i(dev_grant)), "R4",
                64'(mem_req_addr), 64'(TBASE + AW'(oh2i(dev_grant))));
            tbl_due = 1'b0;
          end else if (exp_fetch.size() == 0) begin
            chk(1'b0, "R5", 64'(mem_req_addr), 64'(0));
          end else begin
            logic [AW-1:0] f;
            f = exp_fetch.pop_front();
            chk(mem_req_addr == f, "R5/R7 fetch", 64'(mem_req_addr), 64'(f));
          end
        end
      end

      // R8: with a long transfer the prefetch has landed, so the next order follows done at once
      if (fast_mode && dev_done && exp_cmd.size() > 0 &&
          exp_cmd[0][CIW-1 -: 3] == 3'(oh2i(dev_grant)))
        chk(cmd_valid, "R8", 64'(cmd_valid), 64'(1));

      // command monitor and device model
      if (cmd_valid) begin
        logic [CIW-1:0] got;
        got = {3'(oh2i(dev_grant)), cmd_write, cmd_count};
        if (exp_cmd.size() == 0) chk(1'b0, "R6", 64'(got), 64'(0));
        else begin
          logic [CIW-1:0] e;
          e = exp_cmd.pop_front();
          chk(got == e, "R6 R11 cmd", 64'(got), 64'(e));
        end
        ddly = int'(cmd_count[2:0]) + 1;
      end else if (ddly > 0) begin
        ddly--;
        if (ddly == 0) dev_done <= 1'b1;
      end
    end
  end

  task automatic wait_idle();
    while (exp_wb.size() != 0 || dev_grant != '0) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;

    // table slots (R4)
    mem[TBASE + 2] = 32'h10;
    mem[TBASE + 3] = 32'h20;
    mem[TBASE + 5] = 32'h40;
    mem[TBASE + 6] = 32'h50;
    mem[TBASE + 0] = 32'h60;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(dev_grant == '0, "R1", 64'(dev_grant), 64'(0));
    chk(!mem_req_valid, "R1", 64'(mem_req_valid), 64'(0));
    chk(!cmd_valid, "R1", 64'(cmd_valid), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk(dev_grant == '0 && !mem_req_valid, "R1", 64'(dev_grant), 64'(0));

    // ---- test A: three devices at once, served by priority ----
    // dev2: read 3, write 2, end
    put(8'h10, 2'b00, 3); put(8'h11, 2'b01, 2); put(8'h12, 2'b11, 0);
    want_cmd(2, 1'b0, 3); want_cmd(2, 1'b1, 2); want_wb(2, 8'h13);
    // dev3: write 1, jump to 0x30 (R7), read 4, end
    put(8'h20, 2'b01, 1); put(8'h21, 2'b10, 8'h30);
    put(8'h30, 2'b00, 4); put(8'h31, 2'b11, 0);
    want_cmd(3, 1'b1, 1); want_cmd(3, 1'b0, 4); want_wb(3, 8'h32);
    // dev5: end at once (R9)
    put(8'h40, 2'b11, 0);
    want_wb(5, 8'h41);

    raise(8'b0010_1100);
    @(negedge clk);
    @(negedge clk);
    // R2: lowest index wins, one cycle after the request is seen
    chk(dev_grant == 8'b0000_0100, "R2", 64'(dev_grant), 64'h04);
    wait_idle();
    chk(mem[TBASE + 3] == 32'h32, "R9", 64'(mem[TBASE + 3]), 64'h32);

    // ---- test B: lock and prefetch timing ----
    fast_mode = 1'b1;
    put(8'h50, 2'b00, 7); put(8'h51, 2'b00, 7);
    put(8'h52, 2'b01, 7); put(8'h53, 2'b11, 0);
    want_cmd(6, 1'b0, 7); want_cmd(6, 1'b0, 7); want_cmd(6, 1'b1, 7); want_wb(6, 8'h54);
    put(8'h60, 2'b00, 0); put(8'h61, 2'b11, 0);
    want_cmd(0, 1'b0, 0); want_wb(0, 8'h62);

    raise(8'b0100_0000);
    @(negedge clk);
    @(negedge clk);
    chk(dev_grant == 8'b0100_0000, "R2", 64'(dev_grant), 64'h40);
    repeat (5) @(negedge clk);
    raise(8'b0000_0001);
    repeat (10) @(negedge clk);
    // R3: a higher-priority request does not take the channel mid-program
    chk(dev_grant == 8'b0100_0000, "R3", 64'(dev_grant), 64'h40);
    while (dev_grant != '0) @(negedge clk);
    @(negedge clk);
    // R11: the waiting device is granted straight after release
    chk(dev_grant == 8'b0000_0001, "R11", 64'(dev_grant), 64'h01);
    wait_idle();
    fast_mode = 1'b0;
    repeat (4) @(negedge clk);

    chk(exp_cmd.size() == 0, "R6", 64'(exp_cmd.size()), 64'(0));
    chk(exp_fetch.size() == 0, "R5", 64'(exp_fetch.size()), 64'(0));
    chk(exp_wb.size() == 0, "R9", 64'(exp_wb.size()), 64'(0));

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule